// File: doc/BRIEF.md
# OLED Panel Power and Initialisation Sequencer

This block brings a small colour OLED panel up and down in a safe order, and moves it into and out of sleep. It drives the panel's active-low reset line and the enable of the panel's high-voltage supply. It also feeds command bytes, each tagged with a command/data flag, to an external byte-stream master through a valid/ready handshake. Every delay is a count of system clock cycles, so the integrator sets the delays from the clock frequency.

On a power-on request the sequencer does the following, in order:
- holds the panel in reset, then releases it and waits for the panel logic to settle;
- streams a fixed initialisation list: unlock, display off, configuration, then a computed grey-scale ramp;
- asks the host to clear the frame memory;
- enables the high-voltage supply and waits for it to stabilise;
- sends display on.

Power-off sends display off and drops the high voltage, then waits for the panel to discharge before it tells the host that the logic supply may be removed. Sleep sends display off and drops the high voltage. Wake restores the high voltage, waits, and sends display on. Requests are pulses. A request that arrives while a sequence runs is held and acted on once the sequence ends.

Top module: `oled_pwr_seq`

## Requirements
- R1: While `rst_n` is low and after it rises, `panel_rst_n` is 0, `hv_en` is 0, `bm_valid` is 0, `logic_off_ok` is 1 and `st_on`, `st_sleep`, `st_busy` are 0.
- R2: After a power-on request, `panel_rst_n` stays low for exactly RST_LOW_CYC cycles with `st_busy` set, and the first byte transfer comes no earlier than RST_WAIT_CYC cycles after `panel_rst_n` rises (exactly RST_WAIT_CYC when `bm_ready` stays high).
- R3: A byte transfers in each cycle where `bm_valid` and `bm_ready` are both high. While `bm_valid` is high and `bm_ready` is low, `bm_valid`, `bm_byte` and `bm_is_cmd` hold their values.
- R4: The power-up stream is, in order: FD 12, AE, A0 74, A1 00, A2 00, A4, A8 3F, AD 8E, B0 0B, B1 31, B3 F0, 8A 64, 8B 78, 8C 64, BB 3A, BE 3E, 87 06, 81 91, 82 50, 83 7D, B8. It is followed by GS_LEN grey bytes, where byte k = 2 + floor(123·k/(GS_LEN−1)). `bm_is_cmd` is 1 on the opcode bytes (the first byte of each group). On argument and grey bytes it equals ARG_AS_CMD.
- R5: After the last list byte, `clr_req` rises while `hv_en` is 0. `hv_en` rises only after `clr_done` has been seen.
- R6: Display on (0xAF with `bm_is_cmd`=1) transfers only while `hv_en` is high, no earlier than HV_WAIT_CYC cycles after `hv_en` rose (exactly HV_WAIT_CYC with `bm_ready` high). `st_on` is set afterwards.
- R7: A sleep request in the on state sends only 0xAE as a command, then clears `hv_en` in the cycle after that transfer and sets `st_sleep`.
- R8: A wake request in sleep sets `hv_en`, waits HV_WAIT_CYC cycles, sends only 0xAF, then sets `st_on`.
- R9: A power-off request sends 0xAE and then clears `hv_en`. `logic_off_ok` rises exactly HV_WAIT_CYC cycles after `hv_en` falls, with `panel_rst_n` low. `logic_off_ok` and `hv_en` are never both high.
- R10: Power-off or sleep requests made while a sequence runs are kept and acted on once it ends. When power-off and wake are both pending in sleep, power-off wins and `hv_en` stays 0.
- R11: Requests that make no sense in a settled state are dropped with no bytes and no output change: power-on or wake while on, sleep while asleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_on_req | input | 1 | Pulse: power the panel up |
| pwr_off_req | input | 1 | Pulse: power the panel down |
| sleep_req | input | 1 | Pulse: enter sleep |
| wake_req | input | 1 | Pulse: leave sleep |
| bm_ready | input | 1 | Byte master accepts the offered byte |
| clr_done | input | 1 | Host has finished clearing frame memory |
| panel_rst_n | output | 1 | Active-low panel reset |
| hv_en | output | 1 | Panel high-voltage supply enable |
| bm_valid | output | 1 | A byte is offered to the byte master |
| bm_byte | output | 8 | Offered byte |
| bm_is_cmd | output | 1 | Offered byte goes to the command path |
| clr_req | output | 1 | Request to clear frame memory |
| logic_off_ok | output | 1 | Logic supply may be removed |
| st_on | output | 1 | Panel on and idle |
| st_sleep | output | 1 | Panel asleep and idle |
| st_busy | output | 1 | A sequence is running |

## Verification
The bench logs every transfer with its cycle and checks the full power-up stream both with `bm_ready` held high and with it high only one cycle in three. A design that moved the byte during a stall would corrupt or repeat list entries. Exact gaps are measured between reset release and the first byte, between `hv_en` rising and display on, and between `hv_en` falling and `logic_off_ok`. An off-by-one timer, or a high voltage enabled before the clear, shows up there. Requests are injected mid-sequence, together (off with wake), and where they make no sense. A design that lost a latched request would stall in the on state. One that acted on a stale wake would bring the high voltage back. One that favoured wake over off would raise `hv_en` on the way down.

// File: rtl/oled_seq_pkg.sv
package oled_seq_pkg;

   typedef enum logic [1:0] {
      ENT_CMD = 2'd0,
      ENT_ARG = 2'd1,
      ENT_END = 2'd2
   } ent_kind_e;

   typedef struct packed {
      ent_kind_e  kind;
      logic [7:0] val;
   } rom_ent_t;

   typedef enum logic [3:0] {
      ST_OFF,
      ST_RST_LO,
      ST_RST_WAIT,
      ST_INIT,
      ST_CLEAR,
      ST_HV_UP,
      ST_SEND_ON,
      ST_ON,
      ST_DOFF_SLP,
      ST_SLEEP,
      ST_DOFF_PWR,
      ST_HV_DN
   } seq_st_e;

   localparam logic [7:0] OP_PANEL_OFF = 8'hAE;
   localparam logic [7:0] OP_PANEL_ON  = 8'hAF;

   // request bit positions
   localparam int RQ_ON   = 0;
   localparam int RQ_OFF  = 1;
   localparam int RQ_SLP  = 2;
   localparam int RQ_WAKE = 3;

endpackage

// File: rtl/oled_seq_rom.sv
module oled_seq_rom
   import oled_seq_pkg::*;
#(
   parameter int GS_LEN = 32,
   parameter int IDX_W  = 7
) (
   input  logic [IDX_W-1:0] idx,
   output rom_ent_t         ent
);

   localparam int FIXED_N = 39;
   localparam int TOTAL_N = FIXED_N + GS_LEN + 1;

   initial begin
      if (GS_LEN < 2) $fatal(1, "oled_seq_rom: GS_LEN must be at least 2");
      if (TOTAL_N > (1 << IDX_W)) $fatal(1, "oled_seq_rom: IDX_W too narrow");
   end

   // bit 8 marks an opcode, bits 7:0 carry the byte
   function automatic rom_ent_t fixed_ent(input int i);
      logic [8:0] e;
      case (i)
         0:  e = 9'h1FD;  1:  e = 9'h012;
         2:  e = 9'h1AE;
         3:  e = 9'h1A0;  4:  e = 9'h074;
         5:  e = 9'h1A1;  6:  e = 9'h000;
         7:  e = 9'h1A2;  8:  e = 9'h000;
         9:  e = 9'h1A4;
         10: e = 9'h1A8;  11: e = 9'h03F;
         12: e = 9'h1AD;  13: e = 9'h08E;
         14: e = 9'h1B0;  15: e = 9'h00B;
         16: e = 9'h1B1;  17: e = 9'h031;
         18: e = 9'h1B3;  19: e = 9'h0F0;
         20: e = 9'h18A;  21: e = 9'h064;
         22: e = 9'h18B;  23: e = 9'h078;
         24: e = 9'h18C;  25: e = 9'h064;
         26: e = 9'h1BB;  27: e = 9'h03A;
         28: e = 9'h1BE;  29: e = 9'h03E;
         30: e = 9'h187;  31: e = 9'h006;
         31+1: e = 9'h181; 33: e = 9'h091;
         34: e = 9'h182;  35: e = 9'h050;
         36: e = 9'h183;  37: e = 9'h07D;
         38: e = 9'h1B8;
         default: e = 9'h000;
      endcase
      return '{kind: (e[8] ? ENT_CMD : ENT_ARG), val: e[7:0]};
   endfunction

   // linear ramp from 2 to 125 across the grey table
   function automatic logic [7:0] gs_val(input int k);
      return 8'(2 + (k * 123) / (GS_LEN - 1));
   endfunction

   always_comb begin
      ent = '{kind: ENT_END, val: 8'h00};
      if (int'(idx) < FIXED_N)
         ent = fixed_ent(int'(idx));
      else if (int'(idx) < FIXED_N + GS_LEN)
         ent = '{kind: ENT_ARG, val: gs_val(int'(idx) - FIXED_N)};
   end

endmodule

// File: rtl/oled_seq_timer.sv
module oled_seq_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [CNT_W-1:0] limit,
   output logic             done
);

   logic [CNT_W-1:0] cnt_q;

   // a wait of N cycles ends when the count reaches N-1
   assign done = (cnt_q >= limit - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (restart) cnt_q <= '0;
      else if (!done)   cnt_q <= cnt_q + CNT_W'(1);
   end

endmodule

// File: rtl/oled_seq_req_latch.sv
module oled_seq_req_latch #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   input  logic [N-1:0] drop,
   output logic [N-1:0] pend
);

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pend[i] <= 1'b0;
         else        pend[i] <= req[i] | (pend[i] & ~drop[i]);
      end

      // R10: a request pulse is never lost on the way in
      a_r10_req_kept: assert property (@(posedge clk) disable iff (!rst_n)
         req[i] |=> pend[i]);
   end

endmodule

// File: rtl/oled_pwr_seq.sv
module oled_pwr_seq
   import oled_seq_pkg::*;
#(
   parameter int RST_LOW_CYC  = 2000,
   parameter int RST_WAIT_CYC = 300,
   parameter int HV_WAIT_CYC  = 10000000,
   parameter int GS_LEN       = 32,
   parameter bit ARG_AS_CMD   = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pwr_on_req,
   input  logic       pwr_off_req,
   input  logic       sleep_req,
   input  logic       wake_req,
   input  logic       bm_ready,
   input  logic       clr_done,
   output logic       panel_rst_n,
   output logic       hv_en,
   output logic       bm_valid,
   output logic [7:0] bm_byte,
   output logic       bm_is_cmd,
   output logic       clr_req,
   output logic       logic_off_ok,
   output logic       st_on,
   output logic       st_sleep,
   output logic       st_busy
);

   localparam int MAX_A   = (RST_LOW_CYC > RST_WAIT_CYC) ? RST_LOW_CYC : RST_WAIT_CYC;
   localparam int CYC_MAX = (MAX_A > HV_WAIT_CYC) ? MAX_A : HV_WAIT_CYC;
   localparam int CNT_W   = $clog2(CYC_MAX + 1);
   localparam int IDX_W   = $clog2(39 + GS_LEN + 1);

   initial begin
      if (RST_LOW_CYC < 1 || RST_WAIT_CYC < 1 || HV_WAIT_CYC < 1)
         $fatal(1, "oled_pwr_seq: every wait must be at least one cycle");
   end

   seq_st_e          st_q, st_d;
   logic [3:0]       pend, drop;
   logic             hv_q;
   logic [IDX_W-1:0] idx_q;
   rom_ent_t         ent;
   logic             rom_flag;
   logic             tmr_done;
   logic [CNT_W-1:0] tmr_lim;
   logic             xfer;

   oled_seq_req_latch #(.N(4)) u_req (
      .clk   (clk),
      .rst_n (rst_n),
      .req   ({wake_req, sleep_req, pwr_off_req, pwr_on_req}),
      .drop  (drop),
      .pend  (pend)
   );

   oled_seq_rom #(.GS_LEN(GS_LEN), .IDX_W(IDX_W)) u_rom (
      .idx (idx_q),
      .ent (ent)
   );

   oled_seq_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (st_d != st_q),
      .limit   (tmr_lim),
      .done    (tmr_done)
   );

   // argument bytes travel on the command path or the data path
   if (ARG_AS_CMD) begin : g_arg_cmd
      assign rom_flag = (ent.kind != ENT_END);
   end else begin : g_arg_data
      assign rom_flag = (ent.kind == ENT_CMD);
   end

   always_comb begin
      unique case (st_q)
         ST_RST_LO:   tmr_lim = CNT_W'(RST_LOW_CYC);
         ST_RST_WAIT: tmr_lim = CNT_W'(RST_WAIT_CYC);
         default:     tmr_lim = CNT_W'(HV_WAIT_CYC);
      endcase
   end

   assign xfer = bm_valid && bm_ready;

   always_comb begin
      st_d = st_q;
      drop = '0;
      unique case (st_q)
         ST_OFF: begin
            drop[RQ_OFF] = 1'b1; drop[RQ_SLP] = 1'b1; drop[RQ_WAKE] = 1'b1;
            if (pend[RQ_ON]) begin
               st_d = ST_RST_LO; drop[RQ_ON] = 1'b1;
            end
         end
         ST_RST_LO:   if (tmr_done) st_d = ST_RST_WAIT;
         ST_RST_WAIT: if (tmr_done) st_d = ST_INIT;
         ST_INIT:     if (ent.kind == ENT_END) st_d = ST_CLEAR;
         ST_CLEAR:    if (clr_done) st_d = ST_HV_UP;
         ST_HV_UP:    if (tmr_done) st_d = ST_SEND_ON;
         ST_SEND_ON:  if (bm_ready) st_d = ST_ON;
         ST_ON: begin
            drop[RQ_ON] = 1'b1; drop[RQ_WAKE] = 1'b1;
            if (pend[RQ_OFF]) begin
               st_d = ST_DOFF_PWR; drop[RQ_OFF] = 1'b1; drop[RQ_SLP] = 1'b1;
            end else if (pend[RQ_SLP]) begin
               st_d = ST_DOFF_SLP; drop[RQ_SLP] = 1'b1;
            end
         end
         ST_DOFF_SLP: if (bm_ready) st_d = ST_SLEEP;
         ST_SLEEP: begin
            drop[RQ_ON] = 1'b1; drop[RQ_SLP] = 1'b1;
            if (pend[RQ_OFF]) begin
               st_d = ST_DOFF_PWR; drop[RQ_OFF] = 1'b1; drop[RQ_WAKE] = 1'b1;
            end else if (pend[RQ_WAKE]) begin
               st_d = ST_HV_UP; drop[RQ_WAKE] = 1'b1;
            end
         end
         ST_DOFF_PWR: if (bm_ready) st_d = ST_HV_DN;
         ST_HV_DN:    if (tmr_done) st_d = ST_OFF;
         default:     st_d = ST_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_OFF;
         hv_q  <= 1'b0;
         idx_q <= '0;
      end else begin
         st_q <= st_d;
         if (st_d == ST_HV_UP && st_q != ST_HV_UP)  hv_q <= 1'b1;
         else if (st_d == ST_SLEEP || st_d == ST_HV_DN) hv_q <= 1'b0;
         if (st_q != ST_INIT) idx_q <= '0;
         else if (xfer)       idx_q <= idx_q + IDX_W'(1);
      end
   end

   assign panel_rst_n  = !(st_q == ST_OFF || st_q == ST_RST_LO);
   assign hv_en        = hv_q;
   assign bm_valid     = (st_q == ST_INIT && ent.kind != ENT_END) || st_q == ST_SEND_ON
                         || st_q == ST_DOFF_SLP || st_q == ST_DOFF_PWR;
   assign bm_byte      = (st_q == ST_INIT) ? ent.val
                       : (st_q == ST_SEND_ON) ? OP_PANEL_ON : OP_PANEL_OFF;
   assign bm_is_cmd    = (st_q == ST_INIT) ? rom_flag : 1'b1;
   assign clr_req      = (st_q == ST_CLEAR);
   assign logic_off_ok = (st_q == ST_OFF);
   assign st_on        = (st_q == ST_ON);
   assign st_sleep     = (st_q == ST_SLEEP);
   assign st_busy      = !(st_q == ST_OFF || st_q == ST_ON || st_q == ST_SLEEP);

   // R3: an offered byte stays put until it is taken
   a_r3_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
      bm_valid && !bm_ready |=> bm_valid && $stable(bm_byte) && $stable(bm_is_cmd));

   // R2: high voltage only with the panel out of reset
   a_r2_hv_needs_rst: assert property (@(posedge clk) disable iff (!rst_n)
      hv_en |-> panel_rst_n);

   // R5: frame clear happens with the high voltage still off
   a_r5_clear_hv_off: assert property (@(posedge clk) disable iff (!rst_n)
      clr_req |-> !hv_en);

   // R6: display on is never offered without the high voltage
   a_r6_on_needs_hv: assert property (@(posedge clk) disable iff (!rst_n)
      bm_valid && bm_is_cmd && bm_byte == OP_PANEL_ON |-> hv_en);

   // R7: the high voltage drops only right after display off was taken
   a_r7_hv_drop_after_off: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hv_en) |-> $past(xfer && bm_is_cmd && bm_byte == OP_PANEL_OFF));

   // R9: logic supply removal never overlaps the high voltage
   a_r9_logic_off_safe: assert property (@(posedge clk) disable iff (!rst_n)
      logic_off_ok |-> !hv_en);

endmodule

// File: tb/oled_pwr_seq_tb.sv
module oled_pwr_seq_tb_top;

   localparam int RST_LOW  = 4;
   localparam int RST_WAIT = 6;
   localparam int HV_WAIT  = 25;
   localparam int GS_N     = 32;
   localparam int FIX_N    = 39;
   localparam int LIST_N   = FIX_N + GS_N;

   // {opcode flag, byte}; arguments on the data path in this bench
   localparam logic [8:0] FIX [0:38] = '{
      9'h1FD, 9'h012, 9'h1AE, 9'h1A0, 9'h074, 9'h1A1, 9'h000, 9'h1A2, 9'h000,
      9'h1A4, 9'h1A8, 9'h03F, 9'h1AD, 9'h08E, 9'h1B0, 9'h00B, 9'h1B1, 9'h031,
      9'h1B3, 9'h0F0, 9'h18A, 9'h064, 9'h18B, 9'h078, 9'h18C, 9'h064, 9'h1BB,
      9'h03A, 9'h1BE, 9'h03E, 9'h187, 9'h006, 9'h181, 9'h091, 9'h182, 9'h050,
      9'h183, 9'h07D, 9'h1B8};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [3:0] req_v = '0;
   logic bm_ready = 1'b1;
   logic clr_done = 1'b0;
   logic panel_rst_n, hv_en, bm_valid, bm_is_cmd, clr_req, logic_off_ok;
   logic st_on, st_sleep, st_busy;
   logic [7:0] bm_byte;

   always #4 clk = ~clk;

   oled_pwr_seq #(
      .RST_LOW_CYC(RST_LOW), .RST_WAIT_CYC(RST_WAIT), .HV_WAIT_CYC(HV_WAIT),
      .GS_LEN(GS_N), .ARG_AS_CMD(1'b0)
   ) dut_i (
      .clk(clk), .rst_n(rst_n),
      .pwr_on_req(req_v[0]), .pwr_off_req(req_v[1]),
      .sleep_req(req_v[2]), .wake_req(req_v[3]),
      .bm_ready(bm_ready), .clr_done(clr_done),
      .panel_rst_n(panel_rst_n), .hv_en(hv_en), .bm_valid(bm_valid),
      .bm_byte(bm_byte), .bm_is_cmd(bm_is_cmd), .clr_req(clr_req),
      .logic_off_ok(logic_off_ok), .st_on(st_on), .st_sleep(st_sleep),
      .st_busy(st_busy)
   );

   int n_chk = 0, n_fail = 0;
   int cyc = 0, rdy_mode = 0, rcnt = 0, ccnt = 0;
   logic [8:0] lg_ent [0:255];
   int lg_cyc [0:255];
   int lg_n = 0;
   int rst_rise = -1, hv_rise = -1, hv_fall = -1, clr_rise = -1, loff_rise = -1;
   int rst_low_n = 0, stall_err = 0;
   logic p_rst = 1'b0, p_hv = 1'b0, p_clr = 1'b0, p_loff = 1'b0;
   logic p_valid = 1'b0, p_ready = 1'b0;
   logic [8:0] p_ent = '0;

   // monitor away from the active edge
   always @(negedge clk) begin
      cyc = cyc + 1;
      if (rst_n) begin
         if (bm_valid && bm_ready && lg_n < 256) begin
            lg_ent[lg_n] = {bm_is_cmd, bm_byte};
            lg_cyc[lg_n] = cyc;
            lg_n = lg_n + 1;
         end
         if (panel_rst_n && !p_rst) rst_rise = cyc;
         if (hv_en && !p_hv) hv_rise = cyc;
         if (!hv_en && p_hv) hv_fall = cyc;
         if (clr_req && !p_clr) clr_rise = cyc;
         if (logic_off_ok && !p_loff) loff_rise = cyc;
         if (!panel_rst_n && st_busy) rst_low_n = rst_low_n + 1;
         if (p_valid && !p_ready && !(bm_valid && {bm_is_cmd, bm_byte} == p_ent))
            stall_err = stall_err + 1;
      end
      p_rst = panel_rst_n; p_hv = hv_en; p_clr = clr_req; p_loff = logic_off_ok;
      p_valid = bm_valid; p_ready = bm_ready; p_ent = {bm_is_cmd, bm_byte};
   end

   // byte master readiness and host clear responder
   always @(posedge clk) begin
      #1;
      bm_ready = (rdy_mode == 0) ? 1'b1 : (rcnt % 3 == 2);
      rcnt = rcnt + 1;
      if (clr_req) ccnt = ccnt + 1; else ccnt = 0;
      clr_done = clr_req && (ccnt == 3);
   end

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   task automatic pulse_req(input logic [3:0] m);
      @(posedge clk); #1 req_v = m;
      @(posedge clk); #1 req_v = '0;
   endtask

   task automatic clr_log();
      lg_n = 0; rst_rise = -1; hv_rise = -1; hv_fall = -1;
      clr_rise = -1; loff_rise = -1; rst_low_n = 0; stall_err = 0;
   endtask

   // 0: st_on, 1: st_sleep, 2: logic_off_ok
   task automatic wait_for(input int what, output bit ok);
      ok = 1'b0;
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         if ((what == 0 && st_on) || (what == 1 && st_sleep) || (what == 2 && logic_off_ok)) begin
            ok = 1'b1;
            break;
         end
      end
      #2;
   endtask

   function automatic logic [8:0] exp_ent(input int i);
      if (i < FIX_N) return FIX[i];
      return {1'b0, 8'(2 + ((i - FIX_N) * 123) / (GS_N - 1))};
   endfunction

   task automatic chk_stream(input string rq);
      int mism = 0, first = -1;
      for (int i = 0; i < LIST_N; i++)
         if (lg_ent[i] !== exp_ent(i)) begin
            mism++;
            if (first < 0) first = i;
         end
      chk(mism == 0, rq, first, -1);
      chk(lg_ent[LIST_N] == 9'h1AF, rq, int'(lg_ent[LIST_N]), 9'h1AF);
   endtask

   initial begin
      #(8 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      bit ok;
      int n0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      // R1 during reset
      chk(!panel_rst_n && !hv_en && !bm_valid && logic_off_ok, "R1 in reset",
          {panel_rst_n, hv_en, bm_valid, logic_off_ok}, 4'b0001);
      #1 rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(!panel_rst_n && !hv_en && !bm_valid && logic_off_ok && !st_on && !st_sleep && !st_busy,
          "R1 after reset", {panel_rst_n, hv_en, bm_valid, st_busy}, 0);

      // power-up with a byte master that is always ready
      clr_log();
      pulse_req(4'b0001);
      wait_for(0, ok);
      chk(ok, "R6 reaches on", ok, 1);
      chk(rst_low_n == RST_LOW, "R2 reset low width", rst_low_n, RST_LOW);
      chk(lg_cyc[0] - rst_rise == RST_WAIT, "R2 reset settle", lg_cyc[0] - rst_rise, RST_WAIT);
      chk(lg_n == LIST_N + 1, "R4 byte count", lg_n, LIST_N + 1);
      chk_stream("R4 stream");
      chk(clr_rise > lg_cyc[LIST_N - 1] && hv_rise > clr_rise, "R5 clear before hv",
          hv_rise - clr_rise, 1);
      chk(lg_cyc[LIST_N] - hv_rise == HV_WAIT, "R6 hv settle", lg_cyc[LIST_N] - hv_rise, HV_WAIT);

      // R11: power-on and wake while on are dropped
      n0 = lg_n;
      pulse_req(4'b1001);
      repeat (60) @(negedge clk);
      chk(lg_n == n0 && hv_en && st_on, "R11 ignored while on", lg_n - n0, 0);

      // R7: sleep
      clr_log();
      pulse_req(4'b0100);
      wait_for(1, ok);
      chk(ok && lg_n == 1 && lg_ent[0] == 9'h1AE, "R7 sleep sends off", int'(lg_ent[0]), 9'h1AE);
      chk(!hv_en && hv_fall == lg_cyc[0] + 1, "R7 hv drop", hv_fall - lg_cyc[0], 1);

      // R11: sleep while asleep dropped, and the earlier wake is not acted on
      pulse_req(4'b0100);
      repeat (2 * HV_WAIT) @(negedge clk);
      chk(st_sleep && !hv_en && lg_n == 1, "R11 stays asleep", lg_n, 1);

      // R8: wake
      clr_log();
      pulse_req(4'b1000);
      wait_for(0, ok);
      chk(ok && lg_n == 1 && lg_ent[0] == 9'h1AF, "R8 wake sends on", int'(lg_ent[0]), 9'h1AF);
      chk(lg_cyc[0] - hv_rise == HV_WAIT, "R8 hv settle", lg_cyc[0] - hv_rise, HV_WAIT);

      // R9: power-off
      clr_log();
      pulse_req(4'b0010);
      wait_for(2, ok);
      chk(ok && lg_n == 1 && lg_ent[0] == 9'h1AE, "R9 off sends off", int'(lg_ent[0]), 9'h1AE);
      chk(hv_fall > lg_cyc[0] && loff_rise - hv_fall == HV_WAIT, "R9 discharge wait",
          loff_rise - hv_fall, HV_WAIT);
      chk(!panel_rst_n && !hv_en, "R9 off state", {panel_rst_n, hv_en}, 0);

      // R3 and R10: stalled byte master, sleep requested mid power-up
      rdy_mode = 1;
      clr_log();
      pulse_req(4'b0001);
      repeat (10) @(posedge clk);
      pulse_req(4'b0100);
      wait_for(1, ok);
      chk(ok, "R10 sleep serviced after power-up", ok, 1);
      chk(lg_n == LIST_N + 2, "R3 stalled byte count", lg_n, LIST_N + 2);
      chk_stream("R3 stalled stream");
      chk(lg_ent[LIST_N + 1] == 9'h1AE, "R10 off after on", int'(lg_ent[LIST_N + 1]), 9'h1AE);
      chk(stall_err == 0, "R3 hold under stall", stall_err, 0);
      chk(rst_low_n == RST_LOW && lg_cyc[0] - rst_rise >= RST_WAIT, "R2 stalled run",
          lg_cyc[0] - rst_rise, RST_WAIT);

      // R10: off and wake together in sleep, off wins
      clr_log();
      pulse_req(4'b1010);
      wait_for(2, ok);
      chk(ok && hv_rise == -1 && lg_n == 1 && lg_ent[0] == 9'h1AE, "R10 off beats wake",
          hv_rise, -1);

      // R10: off requested mid power-up
      rdy_mode = 0;
      clr_log();
      pulse_req(4'b0001);
      repeat (20) @(posedge clk);
      pulse_req(4'b0010);
      wait_for(2, ok);
      chk(ok && lg_n == LIST_N + 2 && lg_ent[LIST_N] == 9'h1AF && lg_ent[LIST_N + 1] == 9'h1AE,
          "R10 off after power-up", lg_n, LIST_N + 2);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule